// File: doc/BRIEF.md
# Serial Character Receiver with Overrun Lockout

This block receives 8-bit characters from an asynchronous serial line using one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. A run-time divider sets the bit rate. The line passes through a synchronizer. The receiver then takes samples at sixteen times the bit rate: a middle sample confirms the start bit, and each data bit and the stop bit are taken at the centre of their bit times. Each finished character, together with its stop-bit error flag, goes into a two-entry queue. A read strobe removes the oldest entry from the queue and holds it on the read port.

If a third character finishes while both queue entries are full, that character is lost. A sticky overrun flag then sets, and the receiver refuses every new frame until the overrun is cleared. The only way to clear it is to drop the receive enable for at least one clock. This also abandons any frame that is part-way in. Reading the queue never affects a character that is still being shifted in.

Top module: `rx_lockout_uart`

## Requirements
- R1: A frame is one low start bit, eight data bits least significant first, and one stop bit. The sample tick period is baud_div+1 clocks, and one bit time is 16 ticks. A received byte appears unchanged on rd_data after it is read.
- R2: serial_in passes through a two-flop synchronizer. data_avail rises on the clock edge where the stop bit is sampled, which is 8 ticks plus 9 bit times after the edge that detects the start. data_avail stays high while the queue is not empty.
- R3: The queue holds two characters and returns them oldest first.
- R4: A low pulse that has ended by the middle-of-start sample is ignored and produces no character.
- R5: A clock with rd_pop high and the queue not empty removes the oldest entry and shows it on rd_data and rd_ferr after that edge. A pop while the queue is empty leaves rd_data, rd_ferr and data_avail unchanged.
- R6: If a character finishes while the queue is full and no pop happens on the same edge, the character is dropped and overrun sets. A pop on the same edge makes room, so the character is stored.
- R7: While overrun is high, no new frame is started, even after the queue has been emptied.
- R8: rx_en low clears overrun and abandons any frame in progress. Entries already in the queue are kept.
- R9: A stop bit sampled as 0 stores the character with its error flag set to 1. The flag appears on rd_ferr when that entry is read.
- R10: Pops made while a character is being shifted in do not change that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Continuous receive enable; low clears overrun and the frame state |
| baud_div | input | 16 | Clocks per sample tick minus one |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| rd_pop | input | 1 | Read strobe, removes the oldest entry |
| rd_data | output | 8 | Last character read |
| rd_ferr | output | 1 | Stop-bit error flag of the last character read |
| data_avail | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky overrun; reception is locked while high |

## Verification
The characters sent use varied bit patterns (alternating bits, all ones, single set bits) at three divider settings. These show whether bit order, centre sampling and tick timing are right. Frames sent back to back without reads fill the queue and then overrun it. Sending a further frame during the lockout shows that the receiver stays locked until the enable is toggled. A short low glitch, a stop bit driven low, an enable drop in the middle of a frame, and pops timed to land during a character's data bits each isolate one corner case. A behavioural model compares all four outputs on every clock, so any timing difference of a single cycle is also caught.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/rxl_sync.sv
module rxl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rxl_frame.sv
module rxl_frame
   import rxl_pkg::*;
#(
   parameter int DW   = 8,
   parameter int OVS  = 16,
   parameter int DIVW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            block,
   input  logic            line,
   input  logic [DIVW-1:0] div,
   output logic            done,
   output logic [DW-1:0]   data,
   output logic            ferr
);
   localparam int TW   = $clog2(OVS);
   localparam int BW   = $clog2(DW);
   localparam int MID  = OVS/2 - 1;
   localparam int LAST = OVS - 1;

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("rxl_frame: OVS must be even and at least 4");
   end
   if (DW < 2) begin : g_bad_dw
      $error("rxl_frame: DW must be at least 2");
   end

   rx_state_e       st_q;
   logic [DIVW-1:0] div_q;
   logic [TW-1:0]   tcnt_q;
   logic [BW-1:0]   bidx_q;
   logic [DW-1:0]   shreg_q;
   logic            tick;
   logic            at_mid;
   logic            at_last;

   assign tick    = (div_q == div);
   assign at_mid  = tick && (tcnt_q == TW'(MID));
   assign at_last = tick && (tcnt_q == TW'(LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         div_q   <= '0;
         tcnt_q  <= '0;
         bidx_q  <= '0;
         shreg_q <= '0;
      end else if (!en) begin
         st_q   <= RX_IDLE;
         div_q  <= '0;
         tcnt_q <= '0;
         bidx_q <= '0;
      end else if (st_q == RX_IDLE) begin
         div_q  <= '0;
         tcnt_q <= '0;
         bidx_q <= '0;
         if (!block && !line) st_q <= RX_START;
      end else begin
         div_q <= tick ? '0 : div_q + 1'b1;
         if (tick) tcnt_q <= at_last ? '0 : tcnt_q + 1'b1;
         unique case (st_q)
            RX_START: if (at_mid) begin
               tcnt_q <= '0;
               st_q   <= line ? RX_IDLE : RX_DATA;
            end
            RX_DATA: if (at_last) begin
               shreg_q <= {line, shreg_q[DW-1:1]};
               if (bidx_q == BW'(DW-1)) begin
                  bidx_q <= '0;
                  st_q   <= RX_STOP;
               end else begin
                  bidx_q <= bidx_q + 1'b1;
               end
            end
            RX_STOP: if (at_last) st_q <= RX_IDLE;
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   assign done = en && (st_q == RX_STOP) && at_last;
   assign data = shreg_q;
   assign ferr = !line;
endmodule

// File: rtl/rxl_fifo.sv
module rxl_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full,
   output logic         pop_ok,
   output logic         push_ok
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxl_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign head    = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
         if (pop_ok)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
         if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
         else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/rx_lockout_uart.sv
module rx_lockout_uart #(
   parameter int DW          = 8,
   parameter int OVS         = 16,
   parameter int DIVW        = 16,
   parameter int DEPTH       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_en,
   input  logic [DIVW-1:0] baud_div,
   input  logic            serial_in,
   input  logic            rd_pop,
   output logic [DW-1:0]   rd_data,
   output logic            rd_ferr,
   output logic            data_avail,
   output logic            overrun
);
   localparam int EW = DW + 1;

   logic          line_s;
   logic          chr_done;
   logic [DW-1:0] chr_data;
   logic          chr_ferr;
   logic [EW-1:0] head;
   logic          fifo_empty, fifo_full, pop_ok, push_ok;
   logic          ovr_q;

   rxl_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .din(serial_in), .dout(line_s)
   );

   rxl_frame #(.DW(DW), .OVS(OVS), .DIVW(DIVW)) frame_i (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .block(ovr_q), .line(line_s),
      .div(baud_div), .done(chr_done), .data(chr_data), .ferr(chr_ferr)
   );

   rxl_fifo #(.W(EW), .DEPTH(DEPTH)) fifo_i (
      .clk(clk), .rst_n(rst_n), .push(chr_done), .din({chr_ferr, chr_data}),
      .pop(rd_pop), .head(head), .empty(fifo_empty), .full(fifo_full),
      .pop_ok(pop_ok), .push_ok(push_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q   <= 1'b0;
         rd_data <= '0;
         rd_ferr <= 1'b0;
      end else begin
         if (!rx_en)                       ovr_q <= 1'b0;
         else if (chr_done && !push_ok)    ovr_q <= 1'b1;
         if (pop_ok) begin
            rd_data <= head[DW-1:0];
            rd_ferr <= head[DW];
         end
      end
   end

   assign data_avail = !fifo_empty;
   assign overrun    = ovr_q;
endmodule

// File: rtl/rxl_chk.sv
module rxl_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_en,
   input logic          rd_pop,
   input logic [DW-1:0] rd_data,
   input logic          data_avail,
   input logic          overrun,
   input logic          chr_done,
   input logic          fifo_full
);
   // R6
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(chr_done && fifo_full && !rd_pop));
   // R8
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !overrun);
   // R7
   lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> !chr_done);
   // R5
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_pop && !data_avail) |=> $stable(rd_data));
   // R2
   avail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chr_done |=> data_avail);
   // R3
   full_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> data_avail);
endmodule

bind rx_lockout_uart rxl_chk #(.DW(DW)) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_pop(rd_pop),
   .rd_data(rd_data), .data_avail(data_avail), .overrun(overrun),
   .chr_done(chr_done), .fifo_full(fifo_full)
);

// File: tb/rx_lockout_uart_tb_top.sv
module rx_lockout_uart_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic [15:0] baud_div = 16'd1;
   logic        serial_in = 1'b1;
   logic        rd_pop = 1'b0;
   logic [7:0]  rd_data;
   logic        rd_ferr, data_avail, overrun;

   int checks = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   rx_lockout_uart dut_i (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_div(baud_div),
      .serial_in(serial_in), .rd_pop(rd_pop), .rd_data(rd_data),
      .rd_ferr(rd_ferr), .data_avail(data_avail), .overrun(overrun)
   );

   // behavioural reference model
   logic [8:0] mq[$];
   logic       m_s1 = 1'b1, m_s2 = 1'b1;
   bit         m_busy = 0, m_ovr = 0;
   int         m_cnt = 0;
   logic [7:0] m_shift = '0;
   logic [7:0] m_rd = '0;
   logic       m_rdf = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mq.delete(); m_s1 = 1'b1; m_s2 = 1'b1; m_busy = 0; m_ovr = 0;
         m_cnt = 0; m_rd = '0; m_rdf = 1'b0;
      end else begin
         automatic logic seen = m_s2;
         automatic int t = int'(baud_div) + 1;
         automatic int b = 16 * t;
         automatic bit done = 0;
         automatic logic [8:0] ent = '0;
         m_s2 = m_s1;
         m_s1 = serial_in;
         if (!rx_en) begin
            m_busy = 0; m_ovr = 0;
         end else if (!m_busy) begin
            if (!m_ovr && seen == 1'b0) begin m_busy = 1; m_cnt = 0; end
         end else begin
            m_cnt++;
            if (m_cnt == 8*t) begin
               if (seen) m_busy = 0;
            end else if (m_cnt > 8*t && (m_cnt - 8*t) % b == 0) begin
               automatic int k = (m_cnt - 8*t) / b;
               if (k <= 8) m_shift[k-1] = seen;
               else begin done = 1; ent = {~seen, m_shift}; m_busy = 0; end
            end
         end
         if (rd_pop && mq.size() > 0) begin
            automatic logic [8:0] h = mq.pop_front();
            m_rd = h[7:0]; m_rdf = h[8];
         end
         if (done) begin
            if (mq.size() < 2) mq.push_back(ent);
            else m_ovr = 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if (data_avail !== (mq.size() > 0)) begin
            bad++; $display("FAIL R2 data_avail act=%0b exp=%0b", data_avail, mq.size() > 0);
         end else if (overrun !== m_ovr) begin
            bad++; $display("FAIL R6 overrun act=%0b exp=%0b", overrun, m_ovr);
         end else if (rd_data !== m_rd || rd_ferr !== m_rdf) begin
            bad++; $display("FAIL R5 rd act=%h/%0b exp=%h/%0b", rd_data, rd_ferr, m_rd, m_rdf);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] v, input logic stopb);
      automatic int b = 16 * (int'(baud_div) + 1);
      @(negedge clk); serial_in = 1'b0; repeat (b) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         serial_in = v[i]; repeat (b) @(negedge clk);
      end
      serial_in = stopb; repeat (b) @(negedge clk);
      serial_in = 1'b1;
   endtask

   task automatic pop_one;
      rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
   endtask

   task automatic drain;
      while (data_avail) pop_one();
   endtask

   initial begin
      idle(3);
      chk(data_avail == 0 && overrun == 0 && rd_data == 0, "R2 reset state", rd_data, 0);
      rst_n = 1'b1; rx_en = 1'b1;
      idle(5);

      // R1 basic byte
      send_frame(8'hA5, 1'b1); idle(4);
      chk(data_avail == 1, "R2 avail after frame", data_avail, 1);
      pop_one();
      chk(rd_data == 8'hA5 && rd_ferr == 0, "R1 byte A5", rd_data, 8'hA5);

      // R3 ordering
      send_frame(8'h3C, 1'b1); send_frame(8'h81, 1'b1); idle(4);
      pop_one(); chk(rd_data == 8'h3C, "R3 first oldest", rd_data, 8'h3C);
      pop_one(); chk(rd_data == 8'h81, "R3 second", rd_data, 8'h81);

      // R5 empty pop
      pop_one();
      chk(rd_data == 8'h81 && data_avail == 0, "R5 empty pop keeps value", rd_data, 8'h81);

      // R4 glitch
      serial_in = 1'b0; idle(4); serial_in = 1'b1; idle(400);
      chk(data_avail == 0, "R4 glitch ignored", data_avail, 0);

      // R6 overrun, R7 lockout
      send_frame(8'h11, 1'b1); send_frame(8'h22, 1'b1); send_frame(8'h33, 1'b1); idle(10);
      chk(overrun == 1, "R6 overrun set", overrun, 1);
      send_frame(8'h44, 1'b1); idle(10);
      pop_one(); chk(rd_data == 8'h11, "R6 kept first", rd_data, 8'h11);
      pop_one(); chk(rd_data == 8'h22, "R6 kept second", rd_data, 8'h22);
      chk(data_avail == 0, "R6 third dropped", data_avail, 0);
      send_frame(8'h66, 1'b1); idle(10);
      chk(data_avail == 0 && overrun == 1, "R7 still locked", data_avail, 0);

      // R8 clear by enable toggle
      rx_en = 1'b0; idle(1); rx_en = 1'b1; idle(1);
      chk(overrun == 0, "R8 overrun cleared", overrun, 0);
      send_frame(8'h55, 1'b1); idle(4);
      pop_one(); chk(rd_data == 8'h55, "R8 reception resumes", rd_data, 8'h55);

      // R8 abandon mid-frame
      fork
         send_frame(8'hFF, 1'b1);
         begin idle(100); rx_en = 1'b0; idle(3); rx_en = 1'b1; end
      join
      idle(50);
      chk(data_avail == 0, "R8 frame abandoned", data_avail, 0);

      // R9 framing error
      send_frame(8'h5A, 1'b0); idle(4);
      pop_one();
      chk(rd_data == 8'h5A && rd_ferr == 1, "R9 ferr stored", {rd_ferr, rd_data}, 9'h15A);
      idle(400); drain();

      // R10 pop during reception
      fork
         begin send_frame(8'h12, 1'b1); send_frame(8'h46, 1'b1); end
         begin
            while (!data_avail) @(negedge clk);
            idle(100); pop_one(); pop_one(); pop_one();
         end
      join
      idle(4);
      chk(rd_data == 8'h12, "R10 first read", rd_data, 8'h12);
      pop_one();
      chk(rd_data == 8'h46 && rd_ferr == 0, "R10 second intact", rd_data, 8'h46);

      // R1 other rates
      baud_div = 16'd0; idle(4);
      send_frame(8'hC3, 1'b1); idle(4); pop_one();
      chk(rd_data == 8'hC3, "R1 div0", rd_data, 8'hC3);
      baud_div = 16'd3; idle(4);
      send_frame(8'h7E, 1'b1); idle(4); pop_one();
      chk(rd_data == 8'h7E, "R1 div3", rd_data, 8'h7E);
      send_frame(8'h01, 1'b1); idle(4); pop_one();
      chk(rd_data == 8'h01, "R1 lsb first", rd_data, 8'h01);

      idle(5);
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule